// File: doc/BRIEF.md
# Multi-Mode PWM Timer Channel

This block is one timer channel. It holds a counter and a single compare register, and it drives a PWM reference level from them. The counter has three ways to count. It can count up and wrap, count down and reload, or count up and then down, turning at each end. The output follows a "high below the compare value" rule. That rule has its own saturation cases at both ends of the compare range. A sticky compare-match flag reports when the count meets the compare value. In the up/down mode, a select code chooses which slope may raise the flag.

The period limit (auto-reload), the compare value and the counting mode are held in shadow registers. These copy the inputs only at an update event or while the counter is stopped. So a new value written part-way through a period takes effect at the start of the next period, and the output does not glitch. While the counter is stopped, the count holds, the shadows follow the inputs, and the flag cannot be set.

Top module: `pwm_tmr_chan`

## Requirements
- R1: During reset the count is 0, the direction output is 0 (up), the compare flag is 0 and the PWM level is 0.
- R2: With mode select 00 and direction input 0, the count steps by one each enabled cycle up to the period limit, then returns to 0. Each return to 0 is an update event.
- R3: With mode select 00 and direction input 1, the count falls by one each enabled cycle. At 0 it reloads the period limit presented on that cycle, and that reload is an update event.
- R4: With any non-zero mode select, the count climbs from 0 to the period limit and falls back to 0. It changes direction at each end without repeating the end value. The direction output shows the hardware's direction (1 = falling), and the direction input is ignored. Reaching 0 on the way down is an update event.
- R5: While counting up and the compare value is not above the period limit, the PWM level is 1 exactly when count < compare.
- R6: While counting down and the compare value is not above the period limit, the PWM level is 1 exactly when count <= compare. A compare value of 0 therefore still gives 1 at count 0.
- R7: A compare value above the period limit holds the PWM level at 1 in every mode.
- R8: In up-counting with a compare value of 0, the PWM level stays 0 for the whole period.
- R9: The flag is raised in the cycle after an enabled cycle whose count equals the compare value, if the direction qualifies. Mode select 00 qualifies either direction. 01 qualifies only the falling slope, 10 only the rising slope, and 11 both.
- R10: The flag stays set until a cycle with the clear input high. If a new match and a clear fall in the same cycle, the flag ends up set.
- R11: Changes to the period limit, compare value, mode select and direction input while counting take effect only at the next update event.
- R12: While the enable is low, the count does not change, the flag is never raised, and the shadows copy the inputs every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable |
| dir_in | input | 1 | Requested direction in edge mode (1 = down) |
| cms_in | input | 2 | Mode select: 00 edge, non-zero up/down with flag slope choice |
| arr_in | input | CNT_W | Period limit (auto-reload) |
| cmp_in | input | CNT_W | Compare value |
| flag_clr | input | 1 | Clears the compare flag |
| pwm_ref | output | 1 | PWM reference level |
| cnt_o | output | CNT_W | Current count |
| dir_o | output | 1 | Current direction (1 = down) |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
Some rules can be checked on every cycle from the count, the direction and the shadow values: the saturation rules at the top and bottom of the compare range, the output floor at count 0 while falling, the hold while stopped, the wrap at the period limit, the turnarounds in the up/down mode, and a flag that stays set. Other behaviour only shows over whole sequences, so the bench scenarios cover it. That includes the full count sequences in each mode, the flag slope choice for each select code, the set-over-clear collision, and the deferred take-up of values written part-way through a period.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

   typedef enum logic [1:0] {
      CM_EDGE      = 2'b00,
      CM_FLAG_DN   = 2'b01,
      CM_FLAG_UP   = 2'b10,
      CM_FLAG_BOTH = 2'b11
   } cmode_e;

   // Does a match at the current slope raise the flag under this select code?
   function automatic logic slope_qualifies(input logic [1:0] cms, input logic down);
      logic q;
      unique case (cms)
         CM_EDGE:      q = 1'b1;
         CM_FLAG_DN:   q = down;
         CM_FLAG_UP:   q = ~down;
         default:      q = 1'b1;
      endcase
      return q;
   endfunction

endpackage

// File: rtl/pwm_tmr_shadow.sv
module pwm_tmr_shadow #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          PRELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] arr_in,
   input  logic [CNT_W-1:0] cmp_in,
   input  logic [1:0]       cms_in,
   output logic [CNT_W-1:0] arr_s,
   output logic [CNT_W-1:0] cmp_s,
   output logic [1:0]       cms_s
);

   generate
      if (PRELOAD) begin : g_buffered
         logic [CNT_W-1:0] arr_q;
         logic [CNT_W-1:0] cmp_q;
         logic [1:0]       cms_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               arr_q <= '0;
               cmp_q <= '0;
               cms_q <= '0;
            end else if (load) begin
               arr_q <= arr_in;
               cmp_q <= cmp_in;
               cms_q <= cms_in;
            end
         end

         assign arr_s = arr_q;
         assign cmp_s = cmp_q;
         assign cms_s = cms_q;
      end else begin : g_direct
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, load};
         assign arr_s = arr_in;
         assign cmp_s = cmp_in;
         assign cms_s = cms_in;
      end
   endgenerate

endmodule

// File: rtl/pwm_tmr_seq.sv
module pwm_tmr_seq
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             dir_in,
   input  logic [1:0]       cms_in,
   input  logic [CNT_W-1:0] arr_in,
   input  logic [CNT_W-1:0] arr_s,
   input  logic [1:0]       cms_s,
   output logic [CNT_W-1:0] cnt_q,
   output logic             dir_q,
   output logic             load
);

   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_n;
   logic             dir_hw;
   logic             upd;
   logic             dir_d;

   always_comb begin
      cnt_n  = cnt_q;
      dir_hw = dir_q;
      upd    = 1'b0;
      if (cnt_en) begin
         if (cms_s == CM_EDGE) begin
            if (!dir_q) begin
               if (cnt_q >= arr_s) begin
                  cnt_n = ZERO;
                  upd   = 1'b1;
               end else begin
                  cnt_n = cnt_q + ONE;
               end
            end else begin
               if (cnt_q == ZERO) begin
                  cnt_n = arr_in;
                  upd   = 1'b1;
               end else begin
                  cnt_n = cnt_q - ONE;
               end
            end
         end else begin
            if (!dir_q) begin
               if (cnt_q >= arr_s) begin
                  if (arr_s == ZERO) begin
                     cnt_n = ZERO;
                     upd   = 1'b1;
                  end else begin
                     cnt_n  = arr_s - ONE;
                     dir_hw = 1'b1;
                  end
               end else begin
                  cnt_n = cnt_q + ONE;
               end
            end else begin
               if (cnt_q == ZERO) begin
                  cnt_n = (arr_in == ZERO) ? ZERO : ONE;
                  upd   = 1'b1;
               end else begin
                  cnt_n = cnt_q - ONE;
               end
            end
         end
      end
   end

   assign load  = ~cnt_en | upd;
   assign dir_d = load ? ((cms_in == CM_EDGE) ? dir_in : 1'b0) : dir_hw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         dir_q <= dir_d;
      end
   end

endmodule

// File: rtl/pwm_tmr_cmp.sv
module pwm_tmr_cmp
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             flag_clr,
   input  logic [CNT_W-1:0] cnt,
   input  logic             down,
   input  logic [CNT_W-1:0] arr_s,
   input  logic [CNT_W-1:0] cmp_s,
   input  logic [1:0]       cms_s,
   output logic             pwm_ref,
   output logic             cmp_flag
);

   logic over_top;
   logic below;
   logic flag_set;

   assign over_top = (cmp_s > arr_s);
   assign below    = down ? (cnt <= cmp_s) : (cnt < cmp_s);
   assign pwm_ref  = over_top | below;

   assign flag_set = cnt_en & (cnt == cmp_s) & slope_qualifies(cms_s, down);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_flag <= 1'b0;
      end else if (flag_set) begin
         cmp_flag <= 1'b1;
      end else if (flag_clr) begin
         cmp_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          PRELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             dir_in,
   input  logic [1:0]       cms_in,
   input  logic [CNT_W-1:0] arr_in,
   input  logic [CNT_W-1:0] cmp_in,
   input  logic             flag_clr,
   output logic             pwm_ref,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dir_o,
   output logic             cmp_flag
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_tmr_chan: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] arr_s;
   logic [CNT_W-1:0] cmp_s;
   logic [1:0]       cms_s;
   logic             load;

   pwm_tmr_shadow #(.CNT_W(CNT_W), .PRELOAD(PRELOAD)) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .arr_in (arr_in),
      .cmp_in (cmp_in),
      .cms_in (cms_in),
      .arr_s  (arr_s),
      .cmp_s  (cmp_s),
      .cms_s  (cms_s)
   );

   pwm_tmr_seq #(.CNT_W(CNT_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_en (cnt_en),
      .dir_in (dir_in),
      .cms_in (cms_in),
      .arr_in (arr_in),
      .arr_s  (arr_s),
      .cms_s  (cms_s),
      .cnt_q  (cnt_o),
      .dir_q  (dir_o),
      .load   (load)
   );

   pwm_tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_en   (cnt_en),
      .flag_clr (flag_clr),
      .cnt      (cnt_o),
      .down     (dir_o),
      .arr_s    (arr_s),
      .cmp_s    (cmp_s),
      .cms_s    (cms_s),
      .pwm_ref  (pwm_ref),
      .cmp_flag (cmp_flag)
   );

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             flag_clr,
   input logic [1:0]       cms_in,
   input logic [CNT_W-1:0] cnt_o,
   input logic             dir_o,
   input logic             pwm_ref,
   input logic             cmp_flag,
   input logic [CNT_W-1:0] arr_s,
   input logic [CNT_W-1:0] cmp_s,
   input logic [1:0]       cms_s
);

   p_hold_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt_o));

   p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && cms_s == 2'b00 && !dir_o && cnt_o >= arr_s) |=> (cnt_o == '0));

   p_top_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && cms_s != 2'b00 && !dir_o && arr_s != '0 && cnt_o == arr_s) |=> dir_o);

   p_bottom_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && cms_s != 2'b00 && dir_o && cnt_o == '0 && cms_in != 2'b00) |=> !dir_o);

   p_down_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_o && cnt_o == '0) |-> pwm_ref);

   p_over_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_s > arr_s) |-> pwm_ref);

   p_zero_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_o && cmp_s == '0) |-> !pwm_ref);

   p_rise_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && cnt_o == cmp_s && cms_s == 2'b10 && !dir_o) |=> cmp_flag);

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag && !flag_clr) |=> cmp_flag);

endmodule

bind pwm_tmr_chan pwm_tmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_en   (cnt_en),
   .flag_clr (flag_clr),
   .cms_in   (cms_in),
   .cnt_o    (cnt_o),
   .dir_o    (dir_o),
   .pwm_ref  (pwm_ref),
   .cmp_flag (cmp_flag),
   .arr_s    (arr_s),
   .cmp_s    (cmp_s),
   .cms_s    (cms_s)
);

// File: tb/tb_pwm_tmr_chan.sv
`timescale 1ns/1ps
module tb_pwm_tmr_chan;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cnt_en;
   logic         dir_in;
   logic [1:0]   cms_in;
   logic [W-1:0] arr_in;
   logic [W-1:0] cmp_in;
   logic         flag_clr;
   logic         pwm_ref;
   logic [W-1:0] cnt_o;
   logic         dir_o;
   logic         cmp_flag;

   always #2.5 clk = ~clk;

   pwm_tmr_chan dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_in(dir_in), .cms_in(cms_in),
      .arr_in(arr_in), .cmp_in(cmp_in), .flag_clr(flag_clr),
      .pwm_ref(pwm_ref), .cnt_o(cnt_o), .dir_o(dir_o), .cmp_flag(cmp_flag)
   );

   typedef struct {
      logic [W-1:0] cnt;
      logic         dir;
      logic         pwm;
      logic         flag;
      string        tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   // reference state, built from the requirements
   logic [W-1:0] m_cnt, m_arr, m_cmp;
   logic [1:0]   m_cms;
   logic         m_dir, m_flag;

   function automatic logic m_pwm();
      if (m_cmp > m_arr) return 1'b1;
      return m_dir ? (m_cnt <= m_cmp) : (m_cnt < m_cmp);
   endfunction

   function automatic logic m_qual();
      case (m_cms)
         2'b01:   return m_dir;
         2'b10:   return ~m_dir;
         default: return 1'b1;
      endcase
   endfunction

   task automatic m_step();
      logic upd;
      logic set;
      upd = 1'b0;
      set = cnt_en && (m_cnt == m_cmp) && m_qual();
      if (set) m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
      if (cnt_en) begin
         if (m_cms == 2'b00 && !m_dir) begin
            if (m_cnt >= m_arr) begin m_cnt = '0; upd = 1'b1; end
            else m_cnt = m_cnt + 1'b1;
         end else if (m_cms == 2'b00) begin
            if (m_cnt == '0) begin m_cnt = arr_in; upd = 1'b1; end
            else m_cnt = m_cnt - 1'b1;
         end else if (!m_dir) begin
            if (m_cnt >= m_arr) begin
               if (m_arr == '0) upd = 1'b1;
               else begin m_cnt = m_arr - 1'b1; m_dir = 1'b1; end
            end else m_cnt = m_cnt + 1'b1;
         end else begin
            if (m_cnt == '0) begin
               m_cnt = (arr_in == '0) ? '0 : W'(1);
               upd = 1'b1;
            end else m_cnt = m_cnt - 1'b1;
         end
      end
      if (!cnt_en || upd) begin
         m_arr = arr_in;
         m_cmp = cmp_in;
         m_cms = cms_in;
         m_dir = (cms_in == 2'b00) ? dir_in : 1'b0;
      end
   endtask

   task automatic compare(input string tag, input logic [W-1:0] ec,
                          input logic ed, input logic ep, input logic ef);
      checks++;
      if (cnt_o !== ec || dir_o !== ed || pwm_ref !== ep || cmp_flag !== ef) begin
         errors++;
         $display("FAIL %s: cnt=%0d dir=%0b pwm=%0b flag=%0b expected cnt=%0d dir=%0b pwm=%0b flag=%0b",
                  tag, cnt_o, dir_o, pwm_ref, cmp_flag, ec, ed, ep, ef);
      end
   endtask

   // driver: applies inputs for n cycles and queues the expected outcome of each
   task automatic drive(input logic en, input logic d, input logic [1:0] cm,
                        input logic [W-1:0] a, input logic [W-1:0] c,
                        input logic clr, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         @(negedge clk);
         cnt_en = en; dir_in = d; cms_in = cm; arr_in = a; cmp_in = c; flag_clr = clr;
         m_step();
         e.cnt = m_cnt; e.dir = m_dir; e.pwm = m_pwm(); e.flag = m_flag; e.tag = tag;
         q.push_back(e);
      end
   endtask

   // monitor: samples just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compare(e.tag, e.cnt, e.dir, e.pwm, e.flag);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cnt_en = 1'b0; dir_in = 1'b0; cms_in = 2'b00;
      arr_in = '0; cmp_in = '0; flag_clr = 1'b0;
      m_cnt = '0; m_arr = '0; m_cmp = '0; m_cms = '0; m_dir = 1'b0; m_flag = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1 reset", '0, 1'b0, 1'b0, 1'b0);
      // drive inputs with reset still asserted, state must stay at reset values
      arr_in = 16'd7; cmp_in = 16'd3; dir_in = 1'b1; cnt_en = 1'b1;
      @(negedge clk);
      compare("R1 reset held", '0, 1'b0, 1'b0, 1'b0);
      cnt_en = 1'b0; arr_in = '0; cmp_in = '0; dir_in = 1'b0;
      rst_n = 1'b1;

      // R2 R5: up counting
      drive(0, 0, 2'b00, 16'd5, 16'd3, 1, 2, "R2 R5 setup");
      drive(1, 0, 2'b00, 16'd5, 16'd3, 0, 14, "R2 R5 up count");
      // R8: zero compare while up
      drive(0, 0, 2'b00, 16'd4, 16'd0, 1, 2, "R8 setup");
      drive(1, 0, 2'b00, 16'd4, 16'd0, 0, 11, "R8 zero duty");
      // R7: compare above limit in each mode
      drive(0, 0, 2'b00, 16'd4, 16'd9, 1, 2, "R7 setup");
      drive(1, 0, 2'b00, 16'd4, 16'd9, 0, 7, "R7 up");
      drive(1, 1, 2'b00, 16'd4, 16'd9, 0, 8, "R7 down");
      drive(0, 0, 2'b11, 16'd4, 16'd9, 0, 2, "R7 center setup");
      drive(1, 0, 2'b11, 16'd4, 16'd9, 0, 10, "R7 center");
      // R3 R6: down counting
      drive(0, 1, 2'b00, 16'd5, 16'd2, 1, 2, "R3 R6 setup");
      drive(1, 1, 2'b00, 16'd5, 16'd2, 0, 14, "R3 R6 down count");
      drive(1, 1, 2'b00, 16'd5, 16'd0, 0, 14, "R6 zero compare down");
      // R4: center counting, direction input toggled and ignored
      drive(0, 0, 2'b11, 16'd4, 16'd2, 1, 2, "R4 setup");
      for (int i = 0; i < 20; i++)
         drive(1, i[0], 2'b11, 16'd4, 16'd2, 0, 1, "R4 center count");
      // R9: slope choice per select code
      drive(0, 0, 2'b01, 16'd4, 16'd2, 1, 2, "R9 setup dn");
      for (int i = 0; i < 10; i++)
         drive(1, 0, 2'b01, 16'd4, 16'd2, i == 3, 1, "R9 falling only");
      drive(0, 0, 2'b10, 16'd4, 16'd2, 1, 2, "R9 setup up");
      for (int i = 0; i < 10; i++)
         drive(1, 0, 2'b10, 16'd4, 16'd2, i == 4, 1, "R9 rising only");
      drive(0, 0, 2'b00, 16'd3, 16'd1, 1, 2, "R9 setup edge");
      drive(1, 0, 2'b00, 16'd3, 16'd1, 0, 5, "R9 edge up flag");
      // R10: clear held through matches, set wins
      drive(1, 0, 2'b00, 16'd3, 16'd1, 1, 9, "R10 clear vs set");
      drive(1, 0, 2'b00, 16'd3, 16'd1, 0, 4, "R10 sticky");
      // R11: mid-period change deferred to update event
      drive(0, 0, 2'b00, 16'd7, 16'd3, 1, 2, "R11 setup");
      drive(1, 0, 2'b00, 16'd7, 16'd3, 0, 3, "R11 first period");
      drive(1, 1, 2'b11, 16'd3, 16'd1, 0, 14, "R11 deferred change");
      // R12: stopped counter holds, no flag even when count equals compare
      drive(1, 0, 2'b00, 16'd6, 16'd9, 1, 3, "R12 run");
      drive(0, 0, 2'b00, 16'd6, m_cnt, 1, 1, "R12 stop");
      drive(0, 1, 2'b00, 16'd2, m_cnt, 0, 5, "R12 held");
      drive(1, 1, 2'b00, 16'd2, 16'd1, 0, 6, "R12 resume");

      @(posedge clk);
      #2;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule